// File: doc/BRIEF.md
# Control Transfer Stage Monitor

This block tracks where the default control pipe currently stands within a control transfer. It publishes that position as a 3-bit stage code. The packet decoder in front of it delivers single-cycle event pulses: a setup packet arrived (with its direction and whether a data stage follows), a data-stage token arrived (with its direction), a status-stage token arrived (with its direction), and the current stage finished. The monitor turns these pulses into the stage code and flags any token that cannot legally occur in the current stage as a sequence error.

The block also keeps a sticky flag that records the arrival of a setup packet. Firmware reads this flag and clears it by writing 0 to it. Writing 1 to the flag leaves it untouched, so a read-modify-write that also updates the stage field cannot lose a setup event that arrives in the meantime. The flag only records the event and raises no interrupt. In software control mode, firmware may also overwrite the stage code through the same write port.

Top module: `ctl_stage_monitor`

## Requirements
- R1: Stage codes are 0 idle/setup, 1 read-data, 2 read-status, 3 write-data, 4 write-status, 5 no-data-status, 6 sequence error and 7 unused; `seq_err` is 1 exactly while the code is 6.
- R2: A setup pulse selects the next stage as follows: 1 when `setup_dir_in`=1 (device to host); 3 when `setup_dir_in`=0 and `setup_has_data`=1; 5 when both are 0.
- R3: A data token whose direction matches the data stage keeps the stage, where IN (`data_dir_in`=1) matches code 1 and OUT matches code 3. A status token moves the stage from 1 to 2 when it is OUT and from 3 to 4 when it is IN. A status token keeps the stage at 2 when it is OUT, and at 4 or 5 when it is IN.
- R4: Any other token moves the stage to 6. This includes a token in stage 0, a token of the wrong kind or direction, and data and status tokens in the same cycle. The stage then stays at 6 until a setup pulse arrives or firmware writes a new code.
- R5: `stage_done` returns stages 2, 4 and 5 to 0 and has no effect in any other stage.
- R6: A setup pulse restarts the sequence from every stage, including 6.
- R7: A setup pulse sets `setup_seen` in the next cycle.
- R8: A CPU write with `cpu_wdata[3]`=0 clears `setup_seen`, and a write with `cpu_wdata[3]`=1 leaves it unchanged. A setup pulse in the same cycle as a clearing write wins, and the flag ends up set.
- R9: A CPU write loads `cpu_wdata[2:0]` into the stage only when `sw_mode`=1. When `sw_mode`=0, the stage field of the write is ignored.
- R10: After synchronous reset, the stage is 0, `setup_seen` is 0 and `seq_err` is 0.
- R11: Stage updates follow a fixed priority: a setup pulse first, then a software-mode stage write, then tokens, then `stage_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_pulse | input | 1 | Setup packet received (one cycle) |
| setup_dir_in | input | 1 | Setup direction, 1 = device to host |
| setup_has_data | input | 1 | Setup announces a nonzero-length data stage |
| data_tok | input | 1 | Data-stage token received (one cycle) |
| data_dir_in | input | 1 | Data token direction, 1 = IN |
| stat_tok | input | 1 | Status-stage token received (one cycle) |
| stat_dir_in | input | 1 | Status token direction, 1 = IN |
| stage_done | input | 1 | Current stage completed (one cycle) |
| sw_mode | input | 1 | Software control mode, enables stage writes |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 4 | Bit 3 setup flag, bits 2:0 stage code |
| stage | output | 3 | Current stage code |
| setup_seen | output | 1 | Sticky setup-received flag |
| seq_err | output | 1 | Sequence error indication |

## Verification
The properties checked on every cycle are the following. A setup pulse always lands on its target stage and sets the flag. The error code is sticky. Completion returns a status stage to idle. Writes are ignored outside software mode, and writing 1 to the flag leaves it unchanged. Only the directed scenarios show whole transfer sequences in their proper order. The same holds for tokens that arrive in the idle stage and for the outcome of simultaneous events. Loading the unused code 7, and recovering from it, is also covered only by the scenarios.

// File: rtl/ctsm_pkg.sv
package ctsm_pkg;

    localparam int STAGE_W = 3;
    localparam int WDATA_W = STAGE_W + 1;
    localparam int FLAG_BIT = STAGE_W;

    typedef enum logic [STAGE_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_RD_DATA = 3'd1,
        ST_RD_STAT = 3'd2,
        ST_WR_DATA = 3'd3,
        ST_WR_STAT = 3'd4,
        ST_ND_STAT = 3'd5,
        ST_SEQ_ERR = 3'd6,
        ST_UNUSED  = 3'd7
    } stage_e;

    typedef struct packed {
        logic setup;
        logic setup_in;
        logic setup_data;
        logic dtok;
        logic dtok_in;
        logic stok;
        logic stok_in;
        logic done;
    } ev_t;

    function automatic stage_e setup_target(input logic dir_in, input logic has_data);
        if (dir_in)
            return ST_RD_DATA;
        else if (has_data)
            return ST_WR_DATA;
        else
            return ST_ND_STAT;
    endfunction

    function automatic stage_e after_data_tok(input stage_e cur, input logic dir_in);
        if (cur == ST_RD_DATA && dir_in)
            return ST_RD_DATA;
        else if (cur == ST_WR_DATA && !dir_in)
            return ST_WR_DATA;
        else
            return ST_SEQ_ERR;
    endfunction

    function automatic stage_e after_stat_tok(input stage_e cur, input logic dir_in);
        stage_e r;
        r = ST_SEQ_ERR;
        case (cur)
            ST_RD_DATA: if (!dir_in) r = ST_RD_STAT;
            ST_RD_STAT: if (!dir_in) r = ST_RD_STAT;
            ST_WR_DATA: if (dir_in)  r = ST_WR_STAT;
            ST_WR_STAT: if (dir_in)  r = ST_WR_STAT;
            ST_ND_STAT: if (dir_in)  r = ST_ND_STAT;
            default:                 r = ST_SEQ_ERR;
        endcase
        return r;
    endfunction

    function automatic logic is_status(input stage_e cur);
        return (cur == ST_RD_STAT) || (cur == ST_WR_STAT) || (cur == ST_ND_STAT);
    endfunction

endpackage

// File: rtl/ctsm_stage_fsm.sv
module ctsm_stage_fsm
    import ctsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ev_t                ev,
    input  logic               sw_load,
    input  logic [STAGE_W-1:0] sw_value,
    output stage_e             cur
);
    stage_e nxt;

    always_comb begin
        nxt = cur;
        if (ev.setup)
            nxt = setup_target(ev.setup_in, ev.setup_data);
        else if (sw_load)
            nxt = stage_e'(sw_value);
        else if (ev.dtok && ev.stok)
            nxt = ST_SEQ_ERR;
        else if (ev.dtok)
            nxt = after_data_tok(cur, ev.dtok_in);
        else if (ev.stok)
            nxt = after_stat_tok(cur, ev.stok_in);
        else if (ev.done && is_status(cur))
            nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= ST_IDLE;
        else
            cur <= nxt;
    end
endmodule

// File: rtl/ctsm_setup_flag.sv
module ctsm_setup_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic wr_en,
    input  logic wr_bit,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_ev)
            flag <= 1'b1;
        else if (wr_en && !wr_bit)
            flag <= 1'b0;
    end
endmodule

// File: rtl/ctl_stage_monitor.sv
module ctl_stage_monitor
    import ctsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               setup_pulse,
    input  logic               setup_dir_in,
    input  logic               setup_has_data,
    input  logic               data_tok,
    input  logic               data_dir_in,
    input  logic               stat_tok,
    input  logic               stat_dir_in,
    input  logic               stage_done,
    input  logic               sw_mode,
    input  logic               cpu_wr,
    input  logic [WDATA_W-1:0] cpu_wdata,
    output logic [STAGE_W-1:0] stage,
    output logic               setup_seen,
    output logic               seq_err
);
    ev_t    ev;
    stage_e cur;

    always_comb begin
        ev.setup      = setup_pulse;
        ev.setup_in   = setup_dir_in;
        ev.setup_data = setup_has_data;
        ev.dtok       = data_tok;
        ev.dtok_in    = data_dir_in;
        ev.stok       = stat_tok;
        ev.stok_in    = stat_dir_in;
        ev.done       = stage_done;
    end

    ctsm_stage_fsm i_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .sw_load  (cpu_wr && sw_mode),
        .sw_value (cpu_wdata[STAGE_W-1:0]),
        .cur      (cur)
    );

    ctsm_setup_flag i_flag (
        .clk    (clk),
        .rst    (rst),
        .set_ev (setup_pulse),
        .wr_en  (cpu_wr),
        .wr_bit (cpu_wdata[FLAG_BIT]),
        .flag   (setup_seen)
    );

    assign stage   = cur;
    assign seq_err = (cur == ST_SEQ_ERR);
endmodule

// File: rtl/ctsm_checker.sv
module ctsm_checker
    import ctsm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               setup_pulse,
    input logic               setup_dir_in,
    input logic               setup_has_data,
    input logic               data_tok,
    input logic               stat_tok,
    input logic               stage_done,
    input logic               sw_mode,
    input logic               cpu_wr,
    input logic [WDATA_W-1:0] cpu_wdata,
    input logic [STAGE_W-1:0] stage,
    input logic               setup_seen,
    input logic               seq_err
);
    logic quiet;
    assign quiet = !setup_pulse && !data_tok && !stat_tok && !stage_done;

    p_setup_rd_r2: assert property (@(posedge clk) disable iff (rst)
        setup_pulse && setup_dir_in |=> stage == 3'd1);
    p_setup_wr_r2: assert property (@(posedge clk) disable iff (rst)
        setup_pulse && !setup_dir_in && setup_has_data |=> stage == 3'd3);
    p_setup_nd_r6: assert property (@(posedge clk) disable iff (rst)
        setup_pulse && !setup_dir_in && !setup_has_data |=> stage == 3'd5);
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        seq_err && !setup_pulse && !(cpu_wr && sw_mode) |=> seq_err && stage == 3'd6);
    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        stage_done && !setup_pulse && !data_tok && !stat_tok && !(cpu_wr && sw_mode)
        && (stage == 3'd2 || stage == 3'd4 || stage == 3'd5) |=> stage == 3'd0);
    p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
        setup_pulse |=> setup_seen);
    p_flag_keep_r8: assert property (@(posedge clk) disable iff (rst)
        cpu_wr && cpu_wdata[FLAG_BIT] && !setup_pulse |=> $stable(setup_seen));
    p_no_sw_write_r9: assert property (@(posedge clk) disable iff (rst)
        !sw_mode && quiet |=> $stable(stage));
endmodule

bind ctl_stage_monitor ctsm_checker i_ctsm_checker (
    .clk            (clk),
    .rst            (rst),
    .setup_pulse    (setup_pulse),
    .setup_dir_in   (setup_dir_in),
    .setup_has_data (setup_has_data),
    .data_tok       (data_tok),
    .stat_tok       (stat_tok),
    .stage_done     (stage_done),
    .sw_mode        (sw_mode),
    .cpu_wr         (cpu_wr),
    .cpu_wdata      (cpu_wdata),
    .stage          (stage),
    .setup_seen     (setup_seen),
    .seq_err        (seq_err)
);

// File: tb/test_ctl_stage_monitor.sv
module test_ctl_stage_monitor;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic setup_pulse = 0, setup_dir_in = 0, setup_has_data = 0;
    logic data_tok = 0, data_dir_in = 0, stat_tok = 0, stat_dir_in = 0;
    logic stage_done = 0, sw_mode = 0, cpu_wr = 0;
    logic [3:0] cpu_wdata = 4'd0;
    logic [2:0] stage;
    logic setup_seen, seq_err;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ctl_stage_monitor i_ctl_stage_monitor (
        .clk(clk), .rst(rst),
        .setup_pulse(setup_pulse), .setup_dir_in(setup_dir_in), .setup_has_data(setup_has_data),
        .data_tok(data_tok), .data_dir_in(data_dir_in),
        .stat_tok(stat_tok), .stat_dir_in(stat_dir_in),
        .stage_done(stage_done), .sw_mode(sw_mode),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .stage(stage), .setup_seen(setup_seen), .seq_err(seq_err)
    );

    task automatic chk(input string req, input logic [2:0] exp_st, input logic exp_fl);
        logic exp_err;
        exp_err = (exp_st == 3'd6);
        checks++;
        if (stage !== exp_st || setup_seen !== exp_fl || seq_err !== exp_err) begin
            errors++;
            $display("FAIL %s: stage=%0d flag=%0b err=%0b expected stage=%0d flag=%0b err=%0b",
                     req, stage, setup_seen, seq_err, exp_st, exp_fl, exp_err);
        end
    endtask

    // drive one cycle of events at a falling edge, clear them at the next
    task automatic clear_ins();
        setup_pulse = 0; data_tok = 0; stat_tok = 0; stage_done = 0; cpu_wr = 0;
    endtask
    task automatic setup(input logic dir_in, input logic has_data);
        setup_pulse = 1; setup_dir_in = dir_in; setup_has_data = has_data;
        @(negedge clk); clear_ins();
    endtask
    task automatic dtok(input logic dir_in);
        data_tok = 1; data_dir_in = dir_in;
        @(negedge clk); clear_ins();
    endtask
    task automatic stok(input logic dir_in);
        stat_tok = 1; stat_dir_in = dir_in;
        @(negedge clk); clear_ins();
    endtask
    task automatic done();
        stage_done = 1;
        @(negedge clk); clear_ins();
    endtask
    task automatic wr(input logic sw, input logic [3:0] d);
        sw_mode = sw; cpu_wr = 1; cpu_wdata = d;
        @(negedge clk); clear_ins(); sw_mode = 0;
    endtask

    task automatic t_reset();
        chk("R10 reset", 3'd0, 1'b0);
    endtask

    task automatic t_read_xfer();
        setup(1, 1);  chk("R2 read setup", 3'd1, 1'b1);
        dtok(1);      chk("R3 IN data keeps", 3'd1, 1'b1);
        stok(0);      chk("R3 OUT status", 3'd2, 1'b1);
        stok(0);      chk("R3 status repeat", 3'd2, 1'b1);
        done();       chk("R5 read done", 3'd0, 1'b1);
    endtask

    task automatic t_write_xfer();
        setup(0, 1);  chk("R2 write setup", 3'd3, 1'b1);
        dtok(0);      chk("R3 OUT data keeps", 3'd3, 1'b1);
        stok(1);      chk("R3 IN status", 3'd4, 1'b1);
        done();       chk("R5 write done", 3'd0, 1'b1);
        setup(0, 0);  chk("R2 no-data setup", 3'd5, 1'b1);
        stok(1);      chk("R3 no-data status", 3'd5, 1'b1);
        done();       chk("R5 no-data done", 3'd0, 1'b1);
    endtask

    task automatic t_seq_err();
        dtok(1);      chk("R4 token in idle", 3'd6, 1'b1);
        setup(1, 1);  chk("R6 restart", 3'd1, 1'b1);
        dtok(0);      chk("R4 wrong dir data", 3'd6, 1'b1);
        stok(1);      chk("R4 error sticky", 3'd6, 1'b1);
        done();       chk("R5 done ignored in err", 3'd6, 1'b1);
        setup(0, 0);  chk("R6 restart from err", 3'd5, 1'b1);
        stok(0);      chk("R4 OUT status no-data", 3'd6, 1'b1);
        setup(0, 1);
        data_tok = 1; data_dir_in = 0; stat_tok = 1; stat_dir_in = 1;
        @(negedge clk); clear_ins();
        chk("R4 both tokens", 3'd6, 1'b1);
        setup(1, 1);
        done();       chk("R5 done ignored in data", 3'd1, 1'b1);
    endtask

    task automatic t_flag_and_sw();
        wr(0, 4'b1000); chk("R8 write 1 keeps / R9 ignored", 3'd1, 1'b1);
        wr(0, 4'b0101); chk("R8 write 0 clears / R9 ignored", 3'd1, 1'b0);
        setup_pulse = 1; setup_dir_in = 0; setup_has_data = 1;
        cpu_wr = 1; cpu_wdata = 4'b0000; sw_mode = 1;
        @(negedge clk); clear_ins(); sw_mode = 0;
        chk("R8 R11 setup beats write", 3'd3, 1'b1);
        wr(1, 4'b1100); chk("R9 sw write", 3'd4, 1'b1);
        sw_mode = 1; cpu_wr = 1; cpu_wdata = 4'b1010; data_tok = 1; data_dir_in = 1;
        @(negedge clk); clear_ins(); sw_mode = 0;
        chk("R11 write beats token", 3'd2, 1'b1);
        wr(1, 4'b1111); chk("R1 code 7 loadable", 3'd7, 1'b1);
        stok(1);        chk("R4 token in code 7", 3'd6, 1'b1);
        wr(1, 4'b1000); chk("R9 sw clears error", 3'd0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_read_xfer();
        t_write_xfer();
        t_seq_err();
        t_flag_and_sw();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule